// File: doc/BRIEF.md
# Stepping Attenuation Serial Controller

This block is the host-side master for a serially programmed audio attenuator that takes 16-bit frames over three wires: a frame-enable line (low while a frame is sent), a serial clock and serial data. A client hands it a target attenuation level and a step size over a valid/ready command port. The block does not jump to the target in one write. It sends one complete frame for each intermediate level, so the attenuator passes through every point on the way and the change stays free of clicks.

Each frame is a zero address byte followed by the attenuation code, both sent most significant bit first. The data changes while the serial clock is low and is sampled by the attenuator on the rising edge. The setup time, the clock half period and the gap between frames are counted in system clock cycles and set by parameters, so the serial timing can be matched to the attenuator's limits at any system clock rate. The block keeps track of the level last written and of whether the attenuator is muted. It starts in the muted state. A mute command sends the mute code, and the first level command after a mute writes its target in a single frame.

Top module: `atten_stepper`

## Requirements
- R1: While reset is asserted and after it is released, `ser_load` is 1, `ser_clk` is 0, `cmd_ready` is 1, `cur_muted` is 1 and `cur_level` is 0.
- R2: Each frame shows exactly 16 rising edges of `ser_clk` while `ser_load` is 0. The first 8 bits are 0 and the last 8 bits are the attenuation code, MSB first. `ser_data` is held constant while `ser_clk` is high, and `ser_clk` is never high while `ser_load` is 1.
- R3: `ser_clk` is 0 when `ser_load` falls. At least `SETUP_CYC` cycles pass between the fall of `ser_load` and the first rise of `ser_clk`. Every high phase and every low phase between bits lasts exactly `HALF_CYC` cycles.
- R4: Between two consecutive frames, `ser_load` stays 1 for at least `GAP_CYC` cycles.
- R5: A level command (`cmd_mute`=0) accepted while muted sends one frame whose code is the target level, then clears `cur_muted` and sets `cur_level` to the target.
- R6: A level command accepted while unmuted sends one frame per step. Each code moves `step` dB from the previous level toward the target, and `cur_level` follows the code of each completed frame.
- R7: When the remaining distance is smaller than the step, the final frame carries the target itself, so the sequence ends exactly on the target.
- R8: A mute command (`cmd_mute`=1) sends one frame with code 0x3F, sets `cur_muted` and leaves `cur_level` unchanged.
- R9: `cmd_ready` is 0 from the cycle after acceptance until the gap after the last frame has ended. A `cmd_valid` seen while `cmd_ready` is 0 is ignored.
- R10: A step of 0 is treated as 1. A target above 62 is treated as 62, and `cur_level` never exceeds 62.
- R11: An unmuted level command whose target equals `cur_level` sends no frame, and `cmd_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken on this cycle if valid |
| cmd_mute | input | 1 | 1: mute command, 0: level command |
| cmd_level | input | 6 | Target attenuation in dB |
| cmd_step | input | 6 | Step size in dB for the walk |
| ser_load | output | 1 | Frame enable, low during a frame |
| ser_clk | output | 1 | Serial clock, data sampled on its rising edge |
| ser_data | output | 1 | Serial data, MSB first |
| cur_level | output | 6 | Level of the last completed non-mute frame |
| cur_muted | output | 1 | Attenuator currently muted |

## Verification
The stepping path is driven with several patterns: an upward walk whose distance is not a multiple of the step, a downward walk with a short final step, a walk with a zero step, and a target above 62. The first two separate correct clamping of the last step from overshooting the target or dropping the last point. The zero-step and over-range cases show whether inputs are sanitised before the walk starts. Separate commands cover the direct write after a mute, the mute frame, a target equal to the current level, and a mute offered while a walk is running. These tell the direct-write path apart from the stepping path and show that commands offered while busy are dropped. The monitor rebuilds every frame from the pins and measures setup, half periods and gaps against the parameters.

// File: rtl/atten_stepper.sv
module atten_stepper #(
  parameter int HALF_CYC  = 50,
  parameter int SETUP_CYC = 32,
  parameter int GAP_CYC   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_mute,
  input  logic [5:0] cmd_level,
  input  logic [5:0] cmd_step,
  output logic       ser_load,
  output logic       ser_clk,
  output logic       ser_data,
  output logic [5:0] cur_level,
  output logic       cur_muted
);
  localparam int MAXC = (HALF_CYC > SETUP_CYC) ? ((HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC)
                                               : ((SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [5:0] TOP_LVL = 6'd62;
  localparam logic [7:0] MUTE_CODE = 8'h3F;

  typedef enum logic [1:0] {IDLE, SETUP, SHIFT, GAP} st_t;
  st_t         state;
  logic [CW-1:0] cnt;
  logic [3:0]  bitn;
  logic [15:0] sr;
  logic [5:0]  tgt_q, step_q, pend_q;
  logic        pend_mute;

  logic [5:0] t_in, s_in;
  assign t_in = (cmd_level > TOP_LVL) ? TOP_LVL : cmd_level;
  assign s_in = (cmd_step == 6'd0) ? 6'd1 : cmd_step;
  assign cmd_ready = (state == IDLE);
  assign ser_data  = !ser_load & sr[15];

  function automatic logic [5:0] step_to(input logic [5:0] c, input logic [5:0] t, input logic [5:0] s);
    logic [5:0] d;
    if (t > c) begin
      d = t - c;
      return c + ((d < s) ? d : s);
    end
    d = c - t;
    return c - ((d < s) ? d : s);
  endfunction

  logic       go, go_mute;
  logic [5:0] go_code;
  always_comb begin
    go = 1'b0;
    go_mute = 1'b0;
    go_code = 6'd0;
    if (state == IDLE && cmd_valid) begin
      if (cmd_mute) begin
        go = 1'b1;
        go_mute = 1'b1;
      end else if (cur_muted) begin
        go = 1'b1;
        go_code = t_in;
      end else if (t_in != cur_level) begin
        go = 1'b1;
        go_code = step_to(cur_level, t_in, s_in);
      end
    end else if (state == GAP && cnt == '0 && !cur_muted && cur_level != tgt_q) begin
      go = 1'b1;
      go_code = step_to(cur_level, tgt_q, step_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sr        <= '0;
      tgt_q     <= '0;
      step_q    <= 6'd1;
      pend_q    <= '0;
      pend_mute <= 1'b0;
      ser_load  <= 1'b1;
      ser_clk   <= 1'b0;
      cur_level <= '0;
      cur_muted <= 1'b1;
    end else begin
      if (state == IDLE && cmd_valid && !cmd_mute) begin
        tgt_q  <= t_in;
        step_q <= s_in;
      end
      if (go) begin
        state     <= SETUP;
        cnt       <= CW'(SETUP_CYC - 1);
        ser_load  <= 1'b0;
        ser_clk   <= 1'b0;
        sr        <= {8'h00, go_mute ? MUTE_CODE : {2'b00, go_code}};
        pend_q    <= go_code;
        pend_mute <= go_mute;
      end else begin
        case (state)
          SETUP:
            if (cnt == '0) begin
              state <= SHIFT;
              cnt   <= CW'(HALF_CYC - 1);
              bitn  <= '0;
            end else cnt <= cnt - 1'b1;
          SHIFT:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!ser_clk) begin
              ser_clk <= 1'b1;
              cnt     <= CW'(HALF_CYC - 1);
            end else if (bitn == 4'd15) begin
              ser_clk  <= 1'b0;
              ser_load <= 1'b1;
              state    <= GAP;
              cnt      <= CW'(GAP_CYC - 1);
              cur_muted <= pend_mute;
              if (!pend_mute) cur_level <= pend_q;
            end else begin
              ser_clk <= 1'b0;
              sr      <= {sr[14:0], 1'b0};
              bitn    <= bitn + 1'b1;
              cnt     <= CW'(HALF_CYC - 1);
            end
          GAP:
            if (cnt == '0) state <= IDLE;
            else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ser_clk |-> !ser_load); // R2
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R2
  AST_LOAD_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_load) |-> !ser_clk); // R3
  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !ser_load |-> !cmd_ready); // R9
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cur_level <= TOP_LVL); // R10
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_muted && $past(!cur_muted) && cur_level != $past(cur_level)) |->
    (((cur_level > $past(cur_level)) ? (cur_level - $past(cur_level)) : ($past(cur_level) - cur_level)) <= step_q)); // R6
  AST_MUTE_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(cur_muted) |-> $stable(cur_level)); // R8
endmodule

// File: tb/atten_stepper_bench.sv
module atten_stepper_bench;
  localparam int HALF = 3, SETUP = 5, GAP = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_mute = 1'b0;
  logic [5:0] cmd_level = '0, cmd_step = '0;
  logic cmd_ready, ser_load, ser_clk, ser_data, cur_muted;
  logic [5:0] cur_level;

  atten_stepper #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) u_atten_stepper (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mute(cmd_mute), .cmd_level(cmd_level), .cmd_step(cmd_step),
    .ser_load(ser_load), .ser_clk(ser_clk), .ser_data(ser_data),
    .cur_level(cur_level), .cur_muted(cur_muted));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int nf = 0;
  logic [7:0] codes [0:15];
  int fmt_err = 0, addr_err = 0, data_err = 0, setup_err = 0, half_err = 0, gap_err = 0, fall_err = 0;
  logic prev_load = 1'b1, prev_clk = 1'b0, had_frame = 1'b0, first_rise = 1'b0, rise_data = 1'b0;
  logic [15:0] shreg = '0;
  int bits = 0, setup_cnt = 0, run = 0, gap_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (prev_load && !ser_load) begin
        if (ser_clk) fall_err++;
        if (had_frame && gap_cnt < GAP) gap_err++;
        first_rise = 1'b0; setup_cnt = 0; run = 0; bits = 0;
      end
      if (!ser_load) begin
        if (ser_clk && !prev_clk) begin
          shreg = {shreg[14:0], ser_data}; bits++; rise_data = ser_data;
          if (!first_rise) begin
            if (setup_cnt < SETUP) setup_err++;
            first_rise = 1'b1;
          end else if (run != HALF) half_err++;
          run = 1;
        end else if (!ser_clk && prev_clk) begin
          if (run != HALF) half_err++;
          run = 1;
        end else begin
          run++;
          if (!first_rise) setup_cnt++;
        end
        if (ser_clk && prev_clk && ser_data != rise_data) data_err++;
      end else if (ser_clk) fmt_err++;
      if (!prev_load && ser_load) begin
        if (prev_clk && run != HALF) half_err++;
        if (bits != 16) fmt_err++;
        if (shreg[15:8] != 8'h00) addr_err++;
        if (nf < 16) codes[nf] = shreg[7:0];
        nf++; had_frame = 1'b1; gap_cnt = 1;
      end else if (ser_load) gap_cnt++;
      prev_load = ser_load; prev_clk = ser_clk;
    end
  end

  task automatic do_cmd(input bit m, input int lvl, input int stp);
    nf = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mute = m; cmd_level = 6'(lvl); cmd_step = 6'(stp);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic expect_seq(input string req, input int n, input int e0, input int e1,
                            input int e2, input int e3, input int e4);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    chk(nf == n, {req, " frame count"}, nf, n);
    for (int i = 0; i < n && i < nf && i < 5; i++)
      chk(codes[i] == 8'(e[i]), {req, " frame code"}, codes[i], e[i]);
  endtask

  task automatic t_reset;
    chk(ser_load == 1'b1, "R1 load idle", ser_load, 1);
    chk(ser_clk == 1'b0, "R1 clk idle", ser_clk, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(cur_muted == 1'b1, "R1 muted", cur_muted, 1);
    chk(cur_level == 6'd0, "R1 level", cur_level, 0);
  endtask

  task automatic t_unmute_direct;
    do_cmd(1'b0, 20, 1);
    expect_seq("R5", 1, 20, 0, 0, 0, 0);
    chk(cur_muted == 1'b0, "R5 unmuted", cur_muted, 0);
    chk(cur_level == 6'd20, "R5 level", cur_level, 20);
  endtask

  task automatic t_walk_up;
    do_cmd(1'b0, 30, 4);
    expect_seq("R6 R7 up", 3, 24, 28, 30, 0, 0);
    chk(cur_level == 6'd30, "R7 lands up", cur_level, 30);
  endtask

  task automatic t_walk_down;
    do_cmd(1'b0, 21, 2);
    expect_seq("R6 R7 down", 5, 28, 26, 24, 22, 21);
    chk(cur_level == 6'd21, "R7 lands down", cur_level, 21);
  endtask

  task automatic t_step_zero;
    do_cmd(1'b0, 24, 0);
    expect_seq("R10 step0", 3, 22, 23, 24, 0, 0);
  endtask

  task automatic t_over_range;
    do_cmd(1'b0, 63, 10);
    expect_seq("R10 clamp62", 4, 34, 44, 54, 62, 0);
    chk(cur_level == 6'd62, "R10 level62", cur_level, 62);
  endtask

  task automatic t_same_level;
    nf = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mute = 1'b0; cmd_level = 6'd62; cmd_step = 6'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b1, "R11 ready stays", cmd_ready, 1);
    repeat (20) @(negedge clk);
    chk(nf == 0, "R11 no frame", nf, 0);
    chk(ser_load == 1'b1, "R11 load high", ser_load, 1);
  endtask

  task automatic t_busy_ignored;
    nf = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mute = 1'b0; cmd_level = 6'd50; cmd_step = 6'd4;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 busy", cmd_ready, 0);
    cmd_mute = 1'b1; cmd_level = 6'd0;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    expect_seq("R9 walk kept", 3, 58, 54, 50, 0, 0);
    chk(cur_muted == 1'b0, "R9 mute ignored", cur_muted, 0);
  endtask

  task automatic t_mute;
    do_cmd(1'b1, 0, 1);
    expect_seq("R8", 1, 8'h3F, 0, 0, 0, 0);
    chk(cur_muted == 1'b1, "R8 muted", cur_muted, 1);
    chk(cur_level == 6'd50, "R8 level kept", cur_level, 50);
    do_cmd(1'b0, 5, 1);
    expect_seq("R5 after mute", 1, 5, 0, 0, 0, 0);
    chk(cur_level == 6'd5, "R5 level5", cur_level, 5);
  endtask

  task automatic t_timing;
    chk(fmt_err == 0, "R2 bit count", fmt_err, 0);
    chk(addr_err == 0, "R2 address byte", addr_err, 0);
    chk(data_err == 0, "R2 data held", data_err, 0);
    chk(fall_err == 0, "R3 clk low at load fall", fall_err, 0);
    chk(setup_err == 0, "R3 setup", setup_err, 0);
    chk(half_err == 0, "R3 half period", half_err, 0);
    chk(gap_err == 0, "R4 gap", gap_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_unmute_direct;
    t_walk_up;
    t_walk_down;
    t_step_zero;
    t_over_range;
    t_same_level;
    t_busy_ignored;
    t_mute;
    t_timing;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule